// File: doc/BRIEF.md
# Up-Counting Timer with Shadowed Divider and Reload

This block is a general-purpose up-counting timer. A clock divider produces a tick every (divider + 1) clock cycles. On each tick the main counter advances from 0 up to a reload limit, then wraps to 0, so one period lasts (reload + 1) ticks. Software programs the divider and the reload limit through a simple single-cycle write/read bus.

Writes to the divider and the reload limit go into preload registers. The counter keeps using the active copies until an update event occurs. An update event happens when the counter wraps. Software can also force one with a command bit. Every update event raises a sticky update flag. The interrupt output is the flag gated by an interrupt enable. A one-pulse mode stops the timer at its first wrap. The flag is cleared by writing 0 to its bit, so a full-word write clears only the bits it writes as 0.

A typical use is silence detection on a serial link. The receiver issues a forced update on each received byte, which restarts the count from zero with freshly applied settings. The flag only rises once the line has stayed idle for a full period.

Register map (3-bit address): 0 = CTRL (bit0 run, bit1 one-pulse, bit2 interrupt enable), 1 = STATUS (bit0 update flag), 2 = CMD (bit0 force update), 3 = COUNT, 4 = DIV preload, 5 = RELOAD preload, 6 = DIVCNT (divider counter), 7 reads 0.

Top module: `shadow_timer`

## Requirements
- R1: A write to DIV (address 4) or RELOAD (address 5) changes only the preload value, which reads back at once. The counter keeps the previous active divider and reload until the next update event.
- R2: While CTRL bit0 (run) is 1, the counter goes 0, 1, …, reload and then wraps to 0. The wrap is a natural update event, one every (reload + 1) × (divider + 1) clock cycles.
- R3: Writing 1 to CMD bit0 (address 2) forces an update. It copies both preloads into the active registers and sets COUNT and DIVCNT to 0 in the same clock. CMD always reads as 0.
- R4: Every update event, natural or forced, sets STATUS bit0 (update flag) on the clock of the event.
- R5: The irq output is 1 exactly when the update flag and CTRL bit2 (interrupt enable) are both 1.
- R6: When CTRL bit1 (one-pulse) is 1, a natural update clears CTRL bit0, so the counter stops at 0.
- R7: A write to STATUS with bit0 = 0 clears the flag. A write with bit0 = 1 leaves it unchanged.
- R8: If a flag-clearing write and an update event fall in the same clock, the flag ends up set.
- R9: COUNT (address 3) and DIVCNT (address 6) take a written value only while run is 0. Writes to them while running are ignored.
- R10: After reset, CTRL, STATUS, COUNT, DIVCNT and DIV read 0, RELOAD reads all ones, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register at addr |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr (combinational) |
| irq | output | 1 | Update interrupt request |

## Verification
On every cycle, the assertions check several rules:
- The active divider and reload stay unchanged except at an update event.
- A forced update zeroes both counters.
- A wrap returns the counter to 0.
- An update always leaves the flag set.
- A one-pulse wrap drops the run bit.
- A stopped counter holds still.

Only the bench's scenarios can show the exact period length for several divider and reload pairs. They also show a reload change deferred to the following period, writes to the counters being ignored while running, and a software clear losing to a simultaneous wrap.

// File: rtl/shtmr_pkg.sv
package shtmr_pkg;

  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_STAT   = 3'd1,
    ADR_CMD    = 3'd2,
    ADR_COUNT  = 3'd3,
    ADR_DIV    = 3'd4,
    ADR_RELOAD = 3'd5,
    ADR_DIVCNT = 3'd6
  } regAddr_e;

  // Bit positions inside CTRL
  localparam int CTRL_RUN   = 0;
  localparam int CTRL_OPM   = 1;
  localparam int CTRL_IRQEN = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;
    logic forceUpd;
    logic cntLoad;
    logic divLoad;
  } dpCtl_t;

endpackage

// File: rtl/shtmr_datapath.sv
module shtmr_datapath
  import shtmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = DATA_W,
  parameter int PSC_W  = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [PSC_W-1:0]  divPre,
  input  logic [CNT_W-1:0]  reloadPre,
  output logic [CNT_W-1:0]  cnt,
  output logic [PSC_W-1:0]  divCnt,
  output logic              natUpd
);

  logic [PSC_W-1:0] divAct;
  logic [CNT_W-1:0] reloadAct;
  logic             tick;

  assign tick   = dpCtl.run && (divCnt == divAct);
  assign natUpd = tick && (cnt == reloadAct);

  // Active (shadow) copies: loaded only on an update event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divAct    <= '0;
      reloadAct <= '1;
    end else if (dpCtl.forceUpd || natUpd) begin
      divAct    <= divPre;
      reloadAct <= reloadPre;
    end
  end

  // Divider counter and main counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      cnt    <= '0;
    end else if (dpCtl.forceUpd) begin
      divCnt <= '0;
      cnt    <= '0;
    end else if (dpCtl.run) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        cnt <= natUpd ? '0 : cnt + 1'b1;
      end
    end else begin
      if (dpCtl.divLoad) divCnt <= loadVal[PSC_W-1:0];
      if (dpCtl.cntLoad) cnt    <= loadVal[CNT_W-1:0];
    end
  end

  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.forceUpd |=> (cnt == '0 && divCnt == '0)); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.forceUpd && !natUpd) |=> ($stable(reloadAct) && $stable(divAct))); // R1

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    natUpd |=> (cnt == '0)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtl.run && !dpCtl.forceUpd && !dpCtl.cntLoad) |=> $stable(cnt)); // R9

endmodule

// File: rtl/shtmr_ctrl.sv
module shtmr_ctrl
  import shtmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = DATA_W,
  parameter int PSC_W  = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              natUpd,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [PSC_W-1:0]  divCnt,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output dpCtl_t            dpCtl,
  output logic [PSC_W-1:0]  divPre,
  output logic [CNT_W-1:0]  reloadPre
);

  logic runQ, opmQ, irqEnQ, flag;
  logic wrCtrl, wrStat, wrCount, wrDiv, wrReload, wrDivCnt, forceUpd;

  assign wrCtrl   = wrEn && (addr == ADR_CTRL);
  assign wrStat   = wrEn && (addr == ADR_STAT);
  assign wrCount  = wrEn && (addr == ADR_COUNT);
  assign wrDiv    = wrEn && (addr == ADR_DIV);
  assign wrReload = wrEn && (addr == ADR_RELOAD);
  assign wrDivCnt = wrEn && (addr == ADR_DIVCNT);
  assign forceUpd = wrEn && (addr == ADR_CMD) && wrData[0];

  // Control bits; one-pulse auto-stop wins over a CTRL write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      opmQ   <= 1'b0;
      irqEnQ <= 1'b0;
    end else begin
      if (wrCtrl) begin
        runQ   <= wrData[CTRL_RUN];
        opmQ   <= wrData[CTRL_OPM];
        irqEnQ <= wrData[CTRL_IRQEN];
      end
      if (natUpd && opmQ) runQ <= 1'b0;
    end
  end

  // Update flag: hardware set wins over write-zero clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (natUpd || forceUpd) begin
      flag <= 1'b1;
    end else if (wrStat && !wrData[0]) begin
      flag <= 1'b0;
    end
  end

  // Preload registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divPre    <= '0;
      reloadPre <= '1;
    end else begin
      if (wrDiv)    divPre    <= wrData[PSC_W-1:0];
      if (wrReload) reloadPre <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    dpCtl.run      = runQ;
    dpCtl.forceUpd = forceUpd;
    dpCtl.cntLoad  = wrCount && !runQ;
    dpCtl.divLoad  = wrDivCnt && !runQ;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADR_CTRL: begin
        rdData[CTRL_RUN]   = runQ;
        rdData[CTRL_OPM]   = opmQ;
        rdData[CTRL_IRQEN] = irqEnQ;
      end
      ADR_STAT:   rdData[0] = flag;
      ADR_COUNT:  rdData = DATA_W'(cnt);
      ADR_DIV:    rdData = DATA_W'(divPre);
      ADR_RELOAD: rdData = DATA_W'(reloadPre);
      ADR_DIVCNT: rdData = DATA_W'(divCnt);
      default:    rdData = '0;
    endcase
  end

  assign irq = flag && irqEnQ;

  AST_FLAG_ON_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (natUpd || forceUpd) |=> flag); // R4

  AST_OPM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (natUpd && opmQ) |=> !runQ); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && !wrData[0] && !natUpd && !forceUpd) |=> !flag); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && natUpd) |=> flag); // R8

endmodule

// File: rtl/shadow_timer.sv
module shadow_timer
  import shtmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = DATA_W,
  parameter int PSC_W  = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  dpCtl_t           dpCtl;
  logic [PSC_W-1:0] divPre;
  logic [CNT_W-1:0] reloadPre;
  logic [CNT_W-1:0] cnt;
  logic [PSC_W-1:0] divCnt;
  logic             natUpd;

  shtmr_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .natUpd(natUpd), .cnt(cnt), .divCnt(divCnt), .rdData(rdData), .irq(irq),
    .dpCtl(dpCtl), .divPre(divPre), .reloadPre(reloadPre)
  );

  shtmr_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .loadVal(wrData),
    .divPre(divPre), .reloadPre(reloadPre),
    .cnt(cnt), .divCnt(divCnt), .natUpd(natUpd)
  );

endmodule

// File: tb/shadow_timer_bench.sv
module shadow_timer_bench;

  localparam int DW = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CMD = 3'd2, A_COUNT = 3'd3,
                         A_DIV = 3'd4, A_RELOAD = 3'd5, A_DIVCNT = 3'd6;

  // Stimulus table: divider, reload, expected one-pulse period in clocks
  localparam int NVEC = 5;
  localparam int VEC_DIV [NVEC] = '{0, 1, 2, 0, 3};
  localparam int VEC_REL [NVEC] = '{3, 5, 2, 0, 7};
  localparam int VEC_EXP [NVEC] = '{4, 12, 9, 1, 32};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          irq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  shadow_timer u_shadow_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [DW-1:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [DW-1:0] d);
    wrEn = 1'b0; addr = a;
    #1;
    d = rdData;
  endtask

  // Count clock edges until the flag reads 1
  task automatic waitFlag(inout int n);
    logic [DW-1:0] s;
    for (int k = 0; k < 500; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      busRead(A_STAT, s);
      if (s[0]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    busRead(A_CTRL, d);   check("R10 ctrl", d, 0);
    busRead(A_STAT, d);   check("R10 status", d, 0);
    busRead(A_COUNT, d);  check("R10 count", d, 0);
    busRead(A_DIVCNT, d); check("R10 divcnt", d, 0);
    busRead(A_DIV, d);    check("R10 div", d, 0);
    busRead(A_RELOAD, d); check("R10 reload", d, 16'hFFFF);
    check("R10 irq", irq, 0);

    // Table walk: one-pulse periods (R2, R6)
    for (int v = 0; v < NVEC; v++) begin
      busWrite(A_CTRL, 0);
      busWrite(A_DIV, DW'(VEC_DIV[v]));
      busWrite(A_RELOAD, DW'(VEC_REL[v]));
      busWrite(A_CMD, 1);
      busWrite(A_STAT, 0);
      busWrite(A_CTRL, 16'h3);
      n = 0;
      waitFlag(n);
      check("R2 period", n, VEC_EXP[v]);
      busRead(A_CTRL, d); check("R6 run cleared", d[0], 0);
      repeat (3) @(negedge clk);
      busRead(A_COUNT, d); check("R6 stopped at zero", d, 0);
    end

    // R9 writes while stopped, R3 forced update
    busWrite(A_CTRL, 0);
    busWrite(A_COUNT, 5);  busRead(A_COUNT, d);  check("R9 count write stopped", d, 5);
    busWrite(A_DIVCNT, 2); busRead(A_DIVCNT, d); check("R9 divcnt write stopped", d, 2);
    busWrite(A_STAT, 0);
    busWrite(A_DIV, 0);
    busWrite(A_RELOAD, 3);
    busWrite(A_CMD, 1);
    busRead(A_COUNT, d);  check("R3 count zero", d, 0);
    busRead(A_DIVCNT, d); check("R3 divcnt zero", d, 0);
    busRead(A_STAT, d);   check("R4 forced flag", d[0], 1);
    busRead(A_CMD, d);    check("R3 cmd reads zero", d, 0);

    // R7 write-one keeps, write-zero clears
    busWrite(A_STAT, 1); busRead(A_STAT, d); check("R7 write one keeps", d[0], 1);
    busWrite(A_STAT, 0); busRead(A_STAT, d); check("R7 write zero clears", d[0], 0);

    // R5 interrupt gating
    busWrite(A_CMD, 1);
    check("R5 irq masked", irq, 0);
    busWrite(A_CTRL, 16'h4);
    check("R5 irq asserted", irq, 1);
    busWrite(A_STAT, 0);
    check("R5 irq after clear", irq, 0);
    busWrite(A_CTRL, 0);

    // R1 preload deferred to next update (active div 0, reload 3)
    busWrite(A_RELOAD, 9);
    busRead(A_RELOAD, d); check("R1 preload readback", d, 9);
    busWrite(A_CTRL, 1);
    n = 0; waitFlag(n);
    check("R1 old reload period", n, 4);
    busWrite(A_STAT, 0);
    n = 1; waitFlag(n);
    check("R1 new reload period", n, 10);
    busWrite(A_CTRL, 0);

    // R9 writes ignored while running
    busWrite(A_DIV, 50);
    busWrite(A_CMD, 1);
    busWrite(A_STAT, 0);
    busWrite(A_CTRL, 1);
    busWrite(A_COUNT, 7);
    busRead(A_COUNT, d); check("R9 count write ignored", d, 0);
    busWrite(A_DIVCNT, 40);
    busRead(A_DIVCNT, d); check("R9 divcnt write ignored", d, 2);
    busWrite(A_CTRL, 0);
    busRead(A_DIVCNT, d); check("R2 divider advancing", d, 3);
    busWrite(A_CMD, 1);
    busRead(A_DIVCNT, d); check("R3 divcnt reset by force", d, 0);

    // R8 clear and wrap in the same clock
    busWrite(A_DIV, 0);
    busWrite(A_RELOAD, 3);
    busWrite(A_CMD, 1);
    busWrite(A_STAT, 0);
    busWrite(A_CTRL, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    busWrite(A_STAT, 0);
    busRead(A_STAT, d); check("R8 set wins", d[0], 1);
    busWrite(A_CTRL, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule